// File: doc/BRIEF.md
# Word Address Pointer with Page-Bounded Stepping

This block keeps the internal word address pointer of a byte-addressed serial memory. A protocol engine passes it the two address bytes of a transaction, most significant first. Once the second byte arrives, the whole pointer is replaced in a single cycle. After that, the engine steps the pointer once for each data byte transferred. The pointer keeps its value between transactions, so a later read that sends no address starts where the previous access stopped.

There are two stepping rules. A write step advances only the five low bits, which select a byte within a 32-byte page. The upper bits stay fixed, so stepping past the end of a page returns to the first byte of that same page. A read step advances the full pointer and wraps from the top of the array to zero. The `ADDR_W` parameter sets the pointer width: 12 bits for a 4096-byte array, 13 bits for an 8192-byte array.

Loading is controlled by a two-state machine.
- `LD_IDLE` moves to `LD_HIGH_HELD` when a high-byte strobe arrives. That byte is staged.
- `LD_HIGH_HELD` returns to `LD_IDLE` on a low-byte strobe and commits the pointer.
- `LD_HIGH_HELD` stays in `LD_HIGH_HELD` on a further high-byte strobe, which replaces the staged byte.
- If both strobes arrive together, the high byte is taken and the low byte is dropped.

A per-cycle update selector picks one action for the pointer: `UPD_HOLD`, `UPD_LOAD`, `UPD_LINEAR` or `UPD_PAGE`.

Top module: `word_ptr_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it, the pointer is 0.
- R2: A high-byte strobe followed by a low-byte strobe sets the pointer to {high[ADDR_W-9:0], low}. Bits of the high byte at and above position ADDR_W-8 are ignored. The high-byte strobe by itself does not change the pointer.
- R3: A low-byte strobe with no staged high byte (state `LD_IDLE`) is ignored, and the pointer keeps its value.
- R4: A write step increments pointer bits [4:0] modulo 32 and holds every higher bit. For example, 0x0A3F becomes 0x0A20.
- R5: A read step increments the full pointer modulo 2^ADDR_W. The highest address (0x1FFF at the default width) becomes 0.
- R6: With no strobe and no step asserted, the pointer holds its value on every cycle.
- R7: A committing low-byte strobe takes priority over any step in the same cycle. The pointer takes the loaded value.
- R8: When read and write steps are asserted in the same cycle, the read rule (R5) applies.
- R9: A second high-byte strobe before the low byte replaces the staged byte. Steps taken while a high byte is staged do not discard it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hi_stb | input | 1 | Stage `addr_byte` as the high address byte |
| addr_lo_stb | input | 1 | Take `addr_byte` as the low address byte and commit the pointer |
| addr_byte | input | 8 | Address byte from the protocol engine |
| step_wr | input | 1 | Page-bounded increment after a written byte |
| step_rd | input | 1 | Full-array increment after a read byte |
| ptr | output | ADDR_W | Current word address |

## Verification
The hardest cases to reach are the two wrap edges. The page wrap needs a pointer sitting on the last byte of a page whose upper bits are non-zero. The array wrap needs the pointer at its all-ones value. Reaching either by stepping would take thousands of cycles, so the bench first loads a pointer one step short of each edge through the normal two-byte sequence, then applies the matching step. To bring out the priority cases, the bench also overlaps a committing low byte with a step, and read with write steps, and checks the resulting pointer.

// File: rtl/word_ptr_pkg.sv
package word_ptr_pkg;

    typedef enum logic [0:0] {
        LD_IDLE,
        LD_HIGH_HELD
    } ld_state_e;

    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_LOAD,
        UPD_LINEAR,
        UPD_PAGE
    } upd_sel_e;

endpackage

// File: rtl/wp_load_fsm.sv
module wp_load_fsm
    import word_ptr_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hi_stb,
    input  logic          lo_stb,
    input  logic [7:0]    byte_in,
    output logic          commit,
    output logic [AW-1:0] commit_addr
);
    localparam int HI_W = AW - 8;

    ld_state_e        state_q;
    ld_state_e        state_d;
    logic [HI_W-1:0]  hi_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // staged high byte, upper bits of the byte discarded
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hi_q <= '0;
        else if (hi_stb) hi_q <= byte_in[HI_W-1:0];
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:      if (hi_stb) state_d = LD_HIGH_HELD;
            LD_HIGH_HELD: if (hi_stb)      state_d = LD_HIGH_HELD;
                          else if (lo_stb) state_d = LD_IDLE;
            default:      state_d = LD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit      = 1'b0;
        commit_addr = {hi_q, byte_in};
        unique case (state_q)
            LD_IDLE:      commit = 1'b0;
            LD_HIGH_HELD: commit = lo_stb && !hi_stb;
            default:      commit = 1'b0;
        endcase
    end

endmodule

// File: rtl/wp_step_logic.sv
module wp_step_logic #(
    parameter int AW = 13,
    parameter int PW = 5
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] lin_nxt,
    output logic [AW-1:0] page_nxt
);
    // full-array step: wraps from all ones to zero by width
    assign lin_nxt = cur + AW'(1);

    generate
        if (AW > PW) begin : g_paged
            logic [PW-1:0] low_nxt;
            assign low_nxt  = cur[PW-1:0] + PW'(1);
            assign page_nxt = {cur[AW-1:PW], low_nxt};
        end else begin : g_flat
            assign page_nxt = cur + AW'(1);
        end
    endgenerate

endmodule

// File: rtl/word_ptr_ctrl.sv
module word_ptr_ctrl
    import word_ptr_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_hi_stb,
    input  logic              addr_lo_stb,
    input  logic [7:0]        addr_byte,
    input  logic              step_wr,
    input  logic              step_rd,
    output logic [ADDR_W-1:0] ptr
);
    logic              load_go;
    logic [ADDR_W-1:0] load_addr;
    logic [ADDR_W-1:0] lin_nxt;
    logic [ADDR_W-1:0] page_nxt;
    upd_sel_e          sel;

    wp_load_fsm #(.AW(ADDR_W)) u_load (
        .clk         (clk),
        .rst_n       (rst_n),
        .hi_stb      (addr_hi_stb),
        .lo_stb      (addr_lo_stb),
        .byte_in     (addr_byte),
        .commit      (load_go),
        .commit_addr (load_addr)
    );

    wp_step_logic #(.AW(ADDR_W), .PW(PAGE_W)) u_step (
        .cur      (ptr),
        .lin_nxt  (lin_nxt),
        .page_nxt (page_nxt)
    );

    // update selection: load, then read step, then write step
    always_comb begin
        if (load_go)      sel = UPD_LOAD;
        else if (step_rd) sel = UPD_LINEAR;
        else if (step_wr) sel = UPD_PAGE;
        else              sel = UPD_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            unique case (sel)
                UPD_HOLD:   ptr <= ptr;
                UPD_LOAD:   ptr <= load_addr;
                UPD_LINEAR: ptr <= lin_nxt;
                UPD_PAGE:   ptr <= page_nxt;
                default:    ptr <= ptr;
            endcase
        end
    end

endmodule

// File: rtl/word_ptr_chk.sv
module word_ptr_chk #(
    parameter int AW = 13,
    parameter int PW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step_wr,
    input logic          step_rd,
    input logic          commit,
    input logic [AW-1:0] commit_addr,
    input logic [AW-1:0] ptr
);
    // R1: pointer cleared by reset
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> ptr == '0);

    // R2, R7: a commit lands the loaded address regardless of steps
    a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ptr == $past(commit_addr));

    // R4: write step stays inside the page
    a_r4_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_wr && !step_rd && !commit) |=>
            (ptr[AW-1:PW] == $past(ptr[AW-1:PW])) &&
            (ptr[PW-1:0] == PW'($past(ptr[PW-1:0]) + 1'b1)));

    // R5, R8: read step walks the whole array
    a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rd && !commit) |=> ptr == AW'($past(ptr) + 1'b1));

    // R6: idle cycles keep the pointer
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_rd && !step_wr && !commit) |=> $stable(ptr));

endmodule

bind word_ptr_ctrl word_ptr_chk #(.AW(ADDR_W), .PW(PAGE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_wr     (step_wr),
    .step_rd     (step_rd),
    .commit      (load_go),
    .commit_addr (load_addr),
    .ptr         (ptr)
);

// File: tb/test_word_ptr_ctrl.sv
`timescale 1ns/1ps
module test_word_ptr_ctrl;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hi_stb = 1'b0;
    logic          lo_stb = 1'b0;
    logic [7:0]    byte_in = 8'h00;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [AW-1:0] ptr;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    word_ptr_ctrl #(.ADDR_W(AW), .PAGE_W(5)) i_word_ptr_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_hi_stb (hi_stb),
        .addr_lo_stb (lo_stb),
        .addr_byte   (byte_in),
        .step_wr     (wr),
        .step_rd     (rd),
        .ptr         (ptr)
    );

    // one clock of stimulus, driven and released on falling edges
    task automatic cycle(input logic h, input logic l, input logic [7:0] b,
                         input logic w, input logic r);
        @(negedge clk);
        hi_stb = h; lo_stb = l; byte_in = b; wr = w; rd = r;
        @(negedge clk);
        hi_stb = 0; lo_stb = 0; byte_in = 8'h00; wr = 0; rd = 0;
    endtask

    task automatic check(input string req, input logic [AW-1:0] exp);
        n_chk++;
        if (ptr !== exp) begin
            n_fail++;
            $display("FAIL %s: ptr=%h expected=%h", req, ptr, exp);
        end
    endtask

    task automatic load(input logic [7:0] hi, input logic [7:0] lo);
        cycle(1, 0, hi, 0, 0);
        cycle(0, 1, lo, 0, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", '0);
    endtask

    task automatic t_load();
        cycle(1, 0, 8'hFF, 0, 0);
        check("R2", 13'h0000);       // staged only
        cycle(0, 1, 8'hA5, 0, 0);
        check("R2", 13'h1FA5);       // top three high bits dropped
        load(8'h12, 8'h34);
        check("R2", 13'h1234);
    endtask

    task automatic t_orphan_low();
        load(8'h04, 8'h56);
        cycle(0, 1, 8'h33, 0, 0);
        check("R3", 13'h0456);
    endtask

    task automatic t_page_wrap();
        load(8'h0A, 8'h3E);
        cycle(0, 0, 8'h00, 1, 0);
        check("R4", 13'h0A3F);
        cycle(0, 0, 8'h00, 1, 0);
        check("R4", 13'h0A20);
        cycle(0, 0, 8'h00, 1, 0);
        check("R4", 13'h0A21);
        load(8'h1F, 8'hFF);
        cycle(0, 0, 8'h00, 1, 0);
        check("R4", 13'h1FE0);
    endtask

    task automatic t_linear_wrap();
        load(8'h0A, 8'h3F);
        cycle(0, 0, 8'h00, 0, 1);
        check("R5", 13'h0A40);
        load(8'h1F, 8'hFF);
        cycle(0, 0, 8'h00, 0, 1);
        check("R5", 13'h0000);
        cycle(0, 0, 8'h00, 0, 1);
        check("R5", 13'h0001);
    endtask

    task automatic t_hold();
        load(8'h07, 8'h77);
        for (int i = 0; i < 5; i++) @(negedge clk);
        check("R6", 13'h0777);
    endtask

    task automatic t_load_priority();
        load(8'h00, 8'h00);
        cycle(1, 0, 8'h05, 0, 0);
        cycle(0, 1, 8'h10, 1, 1);
        check("R7", 13'h0510);
    endtask

    task automatic t_both_steps();
        load(8'h05, 8'h1F);
        cycle(0, 0, 8'h00, 1, 1);
        check("R8", 13'h0520);
    endtask

    task automatic t_restage();
        cycle(1, 0, 8'h01, 0, 0);
        cycle(1, 0, 8'h02, 0, 0);
        cycle(0, 1, 8'h00, 0, 0);
        check("R9", 13'h0200);
        cycle(1, 0, 8'h03, 0, 0);
        cycle(0, 0, 8'h00, 0, 1);
        check("R9", 13'h0201);       // step applied, stage kept
        cycle(0, 1, 8'h04, 0, 0);
        check("R9", 13'h0304);
    endtask

    initial begin
        t_reset();
        t_load();
        t_orphan_low();
        t_page_wrap();
        t_linear_wrap();
        t_hold();
        t_load_priority();
        t_both_steps();
        t_restage();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule